// File: doc/BRIEF.md
# Event-Linked Port Controller

This block connects sixteen general-purpose pins (two 8-bit ports) to an on-chip event network in both directions. It has four link units. A unit set up as a source watches its pins and raises an event on a chosen edge or level. A unit set up as a target acts on the pins when an incoming trigger arrives. It can set, clear or toggle them, copy a buffer register onto them, or capture their current levels into that buffer.

In single-pin mode, each of the four units selects one pin by its index. In group mode, units 0 and 1 each take their pins from a 16-bit mask, and units 2 and 3 do nothing. A small synchronous register interface holds the configuration, the port data register and the buffer register. Pin inputs pass through a two-flop synchroniser before any detection or capture.

Top module: `evlink_port`

## Requirements
- R1: After synchronous reset, pin_out, evt_out and every readable register are zero.
- R2: A write with cfg_we high lands on the next rising edge, and cfg_rdata shows the addressed register combinationally. The addresses are: 0 mode (bit 0 set selects group mode), 1 to 4 unit 0 to 3 configuration (bits 10:0), 5 and 6 group masks 0 and 1, 7 port data (drives pin_out), 8 buffer, 9 synchronised pin levels (read only). Reads of any other address return zero.
- R3: In single-pin mode, the pin a unit acts on or watches is given by configuration bits 3:0, which hold the pin index.
- R4: In group mode, units 0 and 1 use group masks 0 and 1. Units 2 and 3 never raise an event, and triggers sent to them change nothing.
- R5: A source unit is one with configuration bit 4 clear. If its bit 5 is clear, it is in edge mode: bit 6 enables rising edges and bit 7 enables falling edges. A pin change seen on the third rising clock edge after it is applied raises evt_out for exactly one cycle.
- R6: A source unit with bit 5 set is in level mode. It holds evt_out high while any of its pins is at the active level, with the same three-edge latency. Bit 6 set means active high, and bit 6 clear means active low.
- R7: A group source raises its event when any member pin meets the condition.
- R8: A target unit has bit 4 set. A trigger on it is applied at the next rising edge, according to the action field in bits 10:8: 0 sets its pins, 1 clears them, 2 toggles them. Action codes 5 to 7 do nothing.
- R9: Action 3 copies the buffer register bits under the unit's pins into the port data register.
- R10: Action 4 captures the synchronised pin levels under the unit's pins into the buffer register.
- R11: A trigger never modifies a bit outside the unit's pins. When several units fire in one cycle, their actions apply in ascending unit order, so the later unit wins. A register write in that same cycle is applied before all of them.
- R12: A target unit never raises an event. A trigger sent to a source unit has no effect on the port or the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Port data register |
| trig_in | input | 4 | Incoming trigger per unit |
| evt_out | output | 4 | Outgoing event per unit |

## Verification
Some properties are checked on every cycle by assertions. No port or buffer bit outside the touched pins ever changes. A target unit never signals, and an edge event always follows an actual change on one of the unit's pins. Units 2 and 3 stay silent in group mode. Other behaviour needs the bench's scenarios: the exact three-edge latency, the one-cycle pulse width, the ascending-order resolution when several triggers coincide, the buffer transfers in both directions, and the any-member behaviour of group sources.

// File: rtl/evlink_port_pkg.sv
package evlink_port_pkg;

    localparam int PORT_W    = 8;
    localparam int NUM_PORTS = 2;
    localparam int PINS      = PORT_W * NUM_PORTS;
    localparam int UNITS     = 4;
    localparam int GROUPS    = 2;
    localparam int SEL_W     = $clog2(PINS);
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = PINS;
    localparam int SYNC_LEN  = 2;

    localparam logic [ADDR_W-1:0] A_MODE   = 4'd0;
    localparam logic [ADDR_W-1:0] A_UNIT0  = 4'd1;
    localparam logic [ADDR_W-1:0] A_GMASK0 = 4'd5;
    localparam logic [ADDR_W-1:0] A_PORT   = 4'd7;
    localparam logic [ADDR_W-1:0] A_BUF    = 4'd8;
    localparam logic [ADDR_W-1:0] A_PINS   = 4'd9;

    typedef logic [PINS-1:0] pins_t;

    typedef enum logic [2:0] {
        ACT_SET  = 3'd0,
        ACT_CLR  = 3'd1,
        ACT_TGL  = 3'd2,
        ACT_BOUT = 3'd3,
        ACT_BIN  = 3'd4
    } act_e;

    typedef struct packed {
        logic [2:0]       act;
        logic             fall_en;
        logic             rise_en;
        logic             level;
        logic             target;
        logic [SEL_W-1:0] sel;
    } unit_cfg_t;

    localparam int CFG_W = $bits(unit_cfg_t);

    function automatic pins_t pin_onehot(input logic [SEL_W-1:0] s);
        pins_t r;
        r    = '0;
        r[s] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/evlink_port_sync.sv
module evlink_port_sync
    import evlink_port_pkg::*;
#(
    parameter int W      = PINS,
    parameter int STAGES = SYNC_LEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= '0;
        end else begin
            chain[0] <= din;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
            prev <= chain[STAGES-1];
        end
    end

    assign cur = chain[STAGES-1];
endmodule

// File: rtl/evlink_port_regs.sv
module evlink_port_regs
    import evlink_port_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  pins_t                        port_q,
    input  pins_t                        buf_q,
    input  pins_t                        pins_cur,
    output logic [DATA_W-1:0]            rdata,
    output logic                         group_mode,
    output unit_cfg_t [UNITS-1:0]        cfg,
    output pins_t [UNITS-1:0]            mask,
    output logic                         port_we,
    output logic                         buf_we
);
    logic                     mode_q;
    unit_cfg_t [UNITS-1:0]    cfg_q;
    pins_t [GROUPS-1:0]       gmask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= 1'b0;
            cfg_q   <= '0;
            gmask_q <= '0;
        end else if (we) begin
            if (addr == A_MODE) mode_q <= wdata[0];
            for (int u = 0; u < UNITS; u++)
                if (int'(addr) == int'(A_UNIT0) + u) cfg_q[u] <= wdata[CFG_W-1:0];
            for (int g = 0; g < GROUPS; g++)
                if (int'(addr) == int'(A_GMASK0) + g) gmask_q[g] <= wdata;
        end
    end

    assign port_we    = we && (addr == A_PORT);
    assign buf_we     = we && (addr == A_BUF);
    assign group_mode = mode_q;
    assign cfg        = cfg_q;

    for (genvar u = 0; u < UNITS; u++) begin : g_mask
        if (u < GROUPS) begin : g_grp
            assign mask[u] = mode_q ? gmask_q[u] : pin_onehot(cfg_q[u].sel);
        end else begin : g_single
            assign mask[u] = mode_q ? '0 : pin_onehot(cfg_q[u].sel);
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_MODE) rdata = DATA_W'(mode_q);
        for (int u = 0; u < UNITS; u++)
            if (int'(addr) == int'(A_UNIT0) + u) rdata = DATA_W'(cfg_q[u]);
        for (int g = 0; g < GROUPS; g++)
            if (int'(addr) == int'(A_GMASK0) + g) rdata = gmask_q[g];
        if (addr == A_PORT) rdata = port_q;
        if (addr == A_BUF)  rdata = buf_q;
        if (addr == A_PINS) rdata = pins_cur;
    end
endmodule

// File: rtl/evlink_port_src.sv
module evlink_port_src
    import evlink_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  is_target,
    input  logic  level_mode,
    input  logic  rise_en,
    input  logic  fall_en,
    input  pins_t mask,
    input  pins_t cur,
    input  pins_t prev,
    output logic  evt
);
    pins_t rise_v, fall_v, lvl_v;
    logic  hit_edge, hit_lvl;

    assign rise_v   = cur & ~prev & {PINS{rise_en}};
    assign fall_v   = ~cur & prev & {PINS{fall_en}};
    assign lvl_v    = rise_en ? cur : ~cur;
    assign hit_edge = |(mask & (rise_v | fall_v));
    assign hit_lvl  = |(mask & lvl_v);

    always_ff @(posedge clk) begin
        if (rst) evt <= 1'b0;
        else     evt <= !is_target && (level_mode ? hit_lvl : hit_edge);
    end

    // R12
    target_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(is_target) |-> !evt);

    // R5
    edge_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (evt && !$past(level_mode)) |-> $past(|((cur ^ prev) & mask)));
endmodule

// File: rtl/evlink_port_tgt.sv
module evlink_port_tgt
    import evlink_port_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [UNITS-1:0]       trig,
    input  logic [UNITS-1:0]       is_target,
    input  logic [UNITS-1:0][2:0]  act,
    input  pins_t [UNITS-1:0]      mask,
    input  pins_t                  cur,
    input  logic                   port_we,
    input  logic                   buf_we,
    input  pins_t                  wdata,
    output pins_t                  port_q,
    output pins_t                  buf_q
);
    pins_t p_n, b_n, touch, btouch;

    always_comb begin
        p_n    = port_we ? wdata : port_q;
        b_n    = buf_we  ? wdata : buf_q;
        touch  = '0;
        btouch = '0;
        for (int u = 0; u < UNITS; u++) begin
            if (trig[u] && is_target[u]) begin
                case (act[u])
                    ACT_SET:  begin p_n = p_n | mask[u];  touch = touch | mask[u]; end
                    ACT_CLR:  begin p_n = p_n & ~mask[u]; touch = touch | mask[u]; end
                    ACT_TGL:  begin p_n = p_n ^ mask[u];  touch = touch | mask[u]; end
                    ACT_BOUT: begin
                        p_n   = (p_n & ~mask[u]) | (b_n & mask[u]);
                        touch = touch | mask[u];
                    end
                    ACT_BIN: begin
                        b_n    = (b_n & ~mask[u]) | (cur & mask[u]);
                        btouch = btouch | mask[u];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            port_q <= '0;
            buf_q  <= '0;
        end else begin
            port_q <= p_n;
            buf_q  <= b_n;
        end
    end

    // R11
    port_outside_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(port_we) |-> (((port_q ^ $past(port_q)) & ~$past(touch)) == '0));

    // R11
    buf_outside_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(buf_we) |-> (((buf_q ^ $past(buf_q)) & ~$past(btouch)) == '0));
endmodule

// File: rtl/evlink_port.sv
module evlink_port
    import evlink_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    input  logic [UNITS-1:0]  trig_in,
    output logic [UNITS-1:0]  evt_out
);
    pins_t                  cur, prev, port_q, buf_q;
    logic                   group_mode, port_we, buf_we;
    unit_cfg_t [UNITS-1:0]  cfg;
    pins_t [UNITS-1:0]      mask;
    logic [UNITS-1:0]       is_tgt;
    logic [UNITS-1:0][2:0]  act;

    evlink_port_sync #(.W(PINS), .STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst(rst), .din(pin_in), .cur(cur), .prev(prev)
    );

    evlink_port_regs u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .port_q(port_q), .buf_q(buf_q), .pins_cur(cur), .rdata(cfg_rdata),
        .group_mode(group_mode), .cfg(cfg), .mask(mask),
        .port_we(port_we), .buf_we(buf_we)
    );

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        assign is_tgt[u] = cfg[u].target;
        assign act[u]    = cfg[u].act;

        evlink_port_src u_src (
            .clk(clk), .rst(rst), .is_target(cfg[u].target),
            .level_mode(cfg[u].level), .rise_en(cfg[u].rise_en),
            .fall_en(cfg[u].fall_en), .mask(mask[u]), .cur(cur), .prev(prev),
            .evt(evt_out[u])
        );
    end

    evlink_port_tgt u_tgt (
        .clk(clk), .rst(rst), .trig(trig_in), .is_target(is_tgt), .act(act),
        .mask(mask), .cur(cur), .port_we(port_we), .buf_we(buf_we),
        .wdata(cfg_wdata), .port_q(port_q), .buf_q(buf_q)
    );

    assign pin_out = port_q;

    // R4
    upper_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(group_mode) |-> (evt_out[UNITS-1:GROUPS] == '0));
endmodule

// File: tb/evlink_port_bench.sv
`timescale 1ns/1ps
module evlink_port_bench;
    logic        clk = 1'b0, rst = 1'b1, cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0, pin_in = '0;
    logic [3:0]  trig_in = '0;
    logic [15:0] cfg_rdata, pin_out;
    logic [3:0]  evt_out;

    evlink_port u_evlink_port (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .trig_in(trig_in), .evt_out(evt_out)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [15:0] exp_port = '0, exp_buf = '0;
    logic [10:0] ucfg [4];
    logic [15:0] gm [2];
    bit mode_b = 1'b0;

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        cfg_addr = a; #1; d = cfg_rdata;
    endtask

    task automatic set_unit(input int u, input logic [10:0] c);
        ucfg[u] = c;
        wr(4'(1 + u), {5'b0, c});
    endtask

    function automatic logic [15:0] umask(input int u);
        if (mode_b) return (u < 2) ? gm[u] : 16'h0;
        return 16'h1 << ucfg[u][3:0];
    endfunction

    task automatic model(input int u, input logic [15:0] m, input logic [15:0] pins);
        logic [10:0] c;
        c = ucfg[u];
        if (!c[4]) return;
        case (c[10:8])
            3'd0: exp_port = exp_port | m;
            3'd1: exp_port = exp_port & ~m;
            3'd2: exp_port = exp_port ^ m;
            3'd3: exp_port = (exp_port & ~m) | (exp_buf & m);
            3'd4: exp_buf  = (exp_buf & ~m) | (pins & m);
            default: ;
        endcase
    endtask

    task automatic fire_chk(input logic [3:0] v, input string tag);
        logic [15:0] d;
        for (int u = 0; u < 4; u++) if (v[u]) model(u, umask(u), pin_in);
        trig_in = v;
        @(posedge clk); @(negedge clk);
        trig_in = '0;
        chk({tag, " port"}, pin_out, exp_port);
        rd(4'd8, d);
        chk({tag, " buf"}, d, exp_buf);
    endtask

    task automatic settle_pins(input logic [15:0] v);
        pin_in = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic exp_evt(input logic [10:0] c, input logic [15:0] m,
                                     input logic [15:0] old, input logic [15:0] nw);
        if (c[4]) return 1'b0;
        if (c[5]) return c[6] ? |(m & nw) : |(m & ~nw);
        return |(m & ((nw & ~old & {16{c[6]}}) | (~nw & old & {16{c[7]}})));
    endfunction

    task automatic chk_evts(input logic [15:0] old, input string tag);
        logic [3:0] e;
        for (int u = 0; u < 4; u++) e[u] = exp_evt(ucfg[u], umask(u), old, pin_in);
        chk(tag, {12'b0, evt_out}, {12'b0, e});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d, old;
        for (int u = 0; u < 4; u++) ucfg[u] = '0;
        gm[0] = '0; gm[1] = '0;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 pin_out", pin_out, 16'h0);
        chk("R1 evt_out", {12'b0, evt_out}, 16'h0);
        rd(4'd1, d); chk("R1 unit0 cfg", d, 16'h0);
        rd(4'd8, d); chk("R1 buffer", d, 16'h0);

        // R2 register access
        wr(4'd2, 16'hFDA3);
        rd(4'd2, d); chk("R2 unit cfg readback", d, 16'h05A3);
        wr(4'd5, 16'hBEEF);
        rd(4'd5, d); chk("R2 group mask readback", d, 16'hBEEF);
        rd(4'd12, d); chk("R2 unmapped read", d, 16'h0);
        wr(4'd5, 16'h0);
        wr(4'd7, 16'h1234); exp_port = 16'h1234;
        chk("R2 port write", pin_out, exp_port);

        // R3 R8 R11 directed single-pin targets
        set_unit(0, {3'd0, 2'b00, 1'b0, 1'b1, 4'd3});
        set_unit(1, {3'd1, 2'b00, 1'b0, 1'b1, 4'd3});
        set_unit(2, 11'h0);
        set_unit(3, 11'h0);
        fire_chk(4'b0001, "R8 R3 set pin3");
        fire_chk(4'b0011, "R11 order clear wins");
        set_unit(0, {3'd2, 2'b00, 1'b0, 1'b1, 4'd3});
        fire_chk(4'b0001, "R8 toggle pin3");
        set_unit(0, {3'd6, 2'b00, 1'b0, 1'b1, 4'd3});
        fire_chk(4'b0001, "R8 unused action");

        // R9 R10 buffer transfers
        wr(4'd8, 16'hA5C3); exp_buf = 16'hA5C3;
        set_unit(2, {3'd3, 2'b00, 1'b0, 1'b1, 4'd5});
        fire_chk(4'b0100, "R9 buffer to port");
        settle_pins(16'hFFFF);
        set_unit(3, {3'd4, 2'b00, 1'b0, 1'b1, 4'd2});
        fire_chk(4'b1000, "R10 pins to buffer");

        // R12 source units ignore triggers; target units stay silent
        set_unit(1, {3'd0, 2'b11, 1'b0, 1'b0, 4'd3});
        set_unit(0, {3'd0, 2'b11, 1'b0, 1'b1, 4'd3});
        fire_chk(4'b0010, "R12 trigger to source");
        old = pin_in;
        settle_pins(pin_in ^ 16'h0008);
        chk("R12 target silent", {15'b0, evt_out[0]}, 16'h0);
        chk("R5 edge seen", {15'b0, evt_out[1]}, 16'h1);
        @(posedge clk); @(negedge clk);
        chk("R5 pulse ends", {15'b0, evt_out[1]}, 16'h0);

        // R8 R9 R10 R11 random single-pin targets
        for (int it = 0; it < 40; it++) begin
            pin_in = 16'($urandom);
            for (int u = 0; u < 4; u++)
                set_unit(u, {3'($urandom % 6), 3'($urandom), 1'b1, 4'($urandom)});
            fire_chk(4'($urandom), "R8 R11 random targets");
        end

        // R3 R5 R6 random single-pin sources
        for (int blk = 0; blk < 5; blk++) begin
            for (int u = 0; u < 4; u++)
                set_unit(u, {3'($urandom), 2'($urandom), 1'($urandom), 1'b0, 4'($urandom)});
            for (int it = 0; it < 8; it++) begin
                old = pin_in;
                settle_pins(16'($urandom));
                chk_evts(old, "R5 R6 R3 random sources");
            end
        end

        // R4 R7 group mode
        wr(4'd0, 16'h1); mode_b = 1'b1;
        wr(4'd5, 16'h00F0); gm[0] = 16'h00F0;
        wr(4'd6, 16'h0F00); gm[1] = 16'h0F00;
        set_unit(0, {3'd0, 2'b01, 1'b1, 1'b0, 4'd0});
        set_unit(1, {3'd2, 2'b00, 1'b0, 1'b1, 4'd0});
        set_unit(2, {3'd0, 2'b00, 1'b0, 1'b1, 4'd1});
        set_unit(3, {3'd0, 2'b00, 1'b1, 1'b0, 4'd0});
        settle_pins(16'h0000);
        chk("R4 upper units silent", {12'b0, evt_out}, 16'h0);
        settle_pins(16'h0040);
        chk("R7 R6 any member level", {12'b0, evt_out}, 16'h1);
        settle_pins(16'h0010);
        chk("R7 other member level", {12'b0, evt_out}, 16'h1);
        fire_chk(4'b0010, "R7 R8 group toggle");
        fire_chk(4'b1100, "R4 upper triggers ignored");
        set_unit(0, {3'd0, 2'b01, 1'b0, 1'b0, 4'd0});
        old = pin_in;
        settle_pins(16'h0090);
        chk_evts(old, "R7 R5 group rising edge");
        old = pin_in;
        settle_pins(16'h0080);
        chk_evts(old, "R7 R5 group falling ignored");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule